// File: doc/BRIEF.md
# Low-Power Request and Wakeup Controller

This block sits at the boundary of a processor core. It turns the core's power-management control bits into three low-power request outputs for the system (doze, nap and sleep). External logic may act on the level of these outputs or on their edges to gate the core clock and power down peripherals. The block also produces a wakeup output that tells the system clock controller to restore the core clock. Wakeup is the OR of several conditions: a pending interrupt, a debug-entry request from any of three sources, an external debug-mode input during a debug session, and a software clock-wake request.

An external unconditional debug request enters through a synchronizer. Only its rising edge creates a debug event, which is a single-cycle pulse. The event also sets a pending flag that stays set until software acknowledges it or external debug mode is entered. The level of that request, independently of any edge, holds wakeup asserted for as long as the request is held. Wakeup is registered in the core clock domain so it is glitch-free. Its consumer must still synchronize it into the system clock domain.

Top module: `lp_wake_ctrl`

## Requirements
- R1: Each bit of `lp_req` (bit 0 doze, bit 1 nap, bit 2 sleep) equals `wait_en & mode_sel[i]` as sampled on the previous rising clock edge, and stays asserted for as many cycles as that condition holds.
- R2: While `rst_n` is low, `lp_req`, `wake_out`, `dbg_event` and `dbg_pend` are all 0. This includes the cycles when every source input is active.
- R3: `irq_pending` high at a clock edge makes `wake_out` high after that edge.
- R4: `dbg_req_bit` or `ext_dbg_en` high at a clock edge makes `wake_out` high after that edge.
- R5: `dbg_session` and `ext_dbg_mode` together make `wake_out` high after the edge. Either one alone does not.
- R6: `clk_wake_req` high at a clock edge makes `wake_out` high after that edge.
- R7: With `SYNC_STAGES`=2, `ude_in` held high makes `wake_out` high from the third edge after it rises. `wake_out` stays high while `ude_in` is held and falls at the third edge after `ude_in` falls. This holds even when no new event occurs.
- R8: A 0-to-1 transition of `ude_in` makes `dbg_event` high for exactly one cycle, following the second edge (`SYNC_STAGES`). Holding `ude_in` high produces no further event.
- R9: `dbg_pend` rises on the edge after `dbg_event`. It clears on the first edge where `sw_ack` or `ext_dbg_mode` is high and no new event is present. A new event takes precedence over a clear in the same cycle.
- R10: With every wakeup source inactive and `ude_in` low, `wake_out` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_en | input | 1 | Wait-enable bit |
| mode_sel | input | 3 | Mode select: bit 0 doze, bit 1 nap, bit 2 sleep |
| irq_pending | input | 1 | A valid interrupt is pending |
| dbg_req_bit | input | 1 | Debug-request control bit |
| ext_dbg_en | input | 1 | External debug-enable input |
| dbg_session | input | 1 | Core is in a debug session |
| ext_dbg_mode | input | 1 | External debug-mode input |
| clk_wake_req | input | 1 | Software request to re-enable the core clock |
| ude_in | input | 1 | Unconditional debug request, asynchronous |
| sw_ack | input | 1 | Software acknowledge of a debug event |
| lp_req | output | 3 | Low-power requests: bit 0 doze, bit 1 nap, bit 2 sleep |
| wake_out | output | 1 | Registered wakeup request |
| dbg_event | output | 1 | One-cycle debug event pulse |
| dbg_pend | output | 1 | Debug event pending acknowledge |

## Verification
If the edge detector holds the wrong state, `dbg_event` shows a repeated pulse, a stretched pulse or a missing pulse. This appears within two cycles of a transition on `ude_in` and stays visible while the request is held. A fault in the synchronizer or the wakeup register shows as `wake_out` rising or falling one cycle away from the third edge after an `ude_in` change. A wrongly merged source shows up in the exhaustive sweep of the six direct wakeup inputs, one cycle after the bad combination is applied. A stale low-power register shows in `lp_req` one cycle after any of the sixteen control combinations.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int unsigned N_LP   = 3;
  localparam int unsigned LP_DOZE  = 0;
  localparam int unsigned LP_NAP   = 1;
  localparam int unsigned LP_SLEEP = 2;

  typedef enum logic [2:0] {
    WS_IRQ     = 3'd0,
    WS_DREQ    = 3'd1,
    WS_DEN     = 3'd2,
    WS_SESSION = 3'd3,
    WS_CLKWAKE = 3'd4,
    WS_UDE     = 3'd5
  } wake_src_e;

  localparam int unsigned N_WSRC = 6;
endpackage

// File: rtl/lpw_mode_decode.sv
module lpw_mode_decode #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wait_en,
  input  logic [N-1:0] mode_sel,
  output logic [N-1:0] lp_req
);
  for (genvar g = 0; g < N; g++) begin : g_mode
    logic req_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= wait_en & mode_sel[g];
    end
    assign lp_req[g] = req_q;

    // R1: without wait-enable on the prior edge no request may be up
    p_no_req_without_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wait_en)) |-> !lp_req[g]);
  end
endmodule

// File: rtl/lpw_ude_sync.sv
module lpw_ude_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ude_in,
  input  logic clr_pend,
  output logic ude_level,
  output logic ude_event,
  output logic ude_pend
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   pend_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain_q[s] <= 1'b0;
      else if (s == 0) chain_q[s] <= ude_in;
      else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];
  end

  assign ude_level = chain_q[LAST];
  assign ude_event = chain_q[LAST] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (ude_event) pend_q <= 1'b1;
    else if (clr_pend)  pend_q <= 1'b0;
  end
  assign ude_pend = pend_q;

  // R8: the event never lasts two cycles
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ude_event |=> !ude_event);
  // R9: pending rises only after an event
  p_pend_after_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(ude_pend)) |-> $past(ude_event));
endmodule

// File: rtl/lpw_wake_merge.sv
module lpw_wake_merge
  import lpw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_WSRC-1:0] src,
  output logic              wake
);
  logic wake_d, wake_q;

  assign wake_d = |src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end
  assign wake = wake_q;

  // R3: a pending interrupt always raises wakeup on the next edge
  p_irq_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(src[WS_IRQ])) |-> wake);
  // R6: clock-wake request always raises wakeup
  p_clkwake_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(src[WS_CLKWAKE])) |-> wake);
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wait_en,
  input  logic [N_LP-1:0] mode_sel,
  input  logic            irq_pending,
  input  logic            dbg_req_bit,
  input  logic            ext_dbg_en,
  input  logic            dbg_session,
  input  logic            ext_dbg_mode,
  input  logic            clk_wake_req,
  input  logic            ude_in,
  input  logic            sw_ack,
  output logic [N_LP-1:0] lp_req,
  output logic            wake_out,
  output logic            dbg_event,
  output logic            dbg_pend
);
  logic              ude_level;
  logic [N_WSRC-1:0] wsrc;

  lpw_mode_decode #(.N(N_LP)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_en  (wait_en),
    .mode_sel (mode_sel),
    .lp_req   (lp_req)
  );

  lpw_ude_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ude (
    .clk       (clk),
    .rst_n     (rst_n),
    .ude_in    (ude_in),
    .clr_pend  (sw_ack | ext_dbg_mode),
    .ude_level (ude_level),
    .ude_event (dbg_event),
    .ude_pend  (dbg_pend)
  );

  always_comb begin
    wsrc             = '0;
    wsrc[WS_IRQ]     = irq_pending;
    wsrc[WS_DREQ]    = dbg_req_bit;
    wsrc[WS_DEN]     = ext_dbg_en;
    wsrc[WS_SESSION] = dbg_session & ext_dbg_mode;
    wsrc[WS_CLKWAKE] = clk_wake_req;
    wsrc[WS_UDE]     = ude_level;
  end

  lpw_wake_merge u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (wsrc),
    .wake  (wake_out)
  );

  // R2: reset holds every output low
  p_reset_quiet_r2: assert property (@(posedge clk)
    !rst_n |-> (lp_req == '0 && !wake_out && !dbg_event && !dbg_pend));
  // R7: a held synchronized debug level keeps wakeup up
  p_ude_holds_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ude_level)) |-> wake_out);
endmodule

// File: tb/sim_lp_wake_ctrl.sv
module sim_lp_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_en = 0, irq_pending = 0, dbg_req_bit = 0, ext_dbg_en = 0;
  logic dbg_session = 0, ext_dbg_mode = 0, clk_wake_req = 0, ude_in = 0, sw_ack = 0;
  logic [2:0] mode_sel = '0;
  logic [2:0] lp_req;
  logic wake_out, dbg_event, dbg_pend;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_wake_ctrl #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wait_en(wait_en), .mode_sel(mode_sel),
    .irq_pending(irq_pending), .dbg_req_bit(dbg_req_bit), .ext_dbg_en(ext_dbg_en),
    .dbg_session(dbg_session), .ext_dbg_mode(ext_dbg_mode), .clk_wake_req(clk_wake_req),
    .ude_in(ude_in), .sw_ack(sw_ack), .lp_req(lp_req), .wake_out(wake_out),
    .dbg_event(dbg_event), .dbg_pend(dbg_pend)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ude_state(input string req, input int ev, input int wk, input int pd);
    chk({req, " event"}, dbg_event, ev);
    chk({req, " wake"}, wake_out, wk);
    chk({req, " pend"}, dbg_pend, pd);
  endtask

  initial begin
    @(negedge clk);
    // R2: outputs quiet in reset, even with sources active
    wait_en = 1; mode_sel = 3'b111; irq_pending = 1; clk_wake_req = 1;
    step(); step();
    chk("R2 lp_req", lp_req, 0);
    chk("R2 wake", wake_out, 0);
    chk("R2 event", dbg_event, 0);
    chk("R2 pend", dbg_pend, 0);
    wait_en = 0; mode_sel = 0; irq_pending = 0; clk_wake_req = 0;
    rst_n = 1;
    step();
    chk("R10 idle wake", wake_out, 0);

    // R1: all wait-enable / mode combinations
    for (int v = 0; v < 16; v++) begin
      wait_en = v[3];
      mode_sel = v[2:0];
      step();
      chk("R1 lp_req", lp_req, v[3] ? v[2:0] : 0);
    end
    // R1: level held over several cycles
    wait_en = 1; mode_sel = 3'b100;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R1 held sleep", lp_req, 4);
    end
    wait_en = 0; mode_sel = 0;
    step();

    // R3 R4 R5 R6 R10: sweep of the six direct wakeup sources
    for (int v = 0; v < 64; v++) begin
      irq_pending = v[0]; dbg_req_bit = v[1]; ext_dbg_en = v[2];
      dbg_session = v[3]; ext_dbg_mode = v[4]; clk_wake_req = v[5];
      step();
      chk("R3 R4 R5 R6 R10 wake", wake_out,
          int'(v[0] | v[1] | v[2] | (v[3] & v[4]) | v[5]));
    end
    irq_pending = 0; dbg_req_bit = 0; ext_dbg_en = 0;
    dbg_session = 0; ext_dbg_mode = 0; clk_wake_req = 0;
    step();
    chk("R10 wake after sweep", wake_out, 0);

    // R7 R8 R9: rising edge of the unconditional request
    ude_in = 1;
    step(); ude_state("R8 edge+1", 0, 0, 0);
    step(); ude_state("R8 edge+2", 1, 0, 0);
    step(); ude_state("R7 edge+3", 0, 1, 1);
    for (int k = 0; k < 4; k++) begin
      step(); ude_state("R8 held no repeat", 0, 1, 1);
    end
    // R9: acknowledge clears pending, R7 wake stays while held
    sw_ack = 1;
    step(); ude_state("R9 ack clears", 0, 1, 0);
    sw_ack = 0;
    step(); ude_state("R7 held after ack", 0, 1, 0);
    // R7: release
    ude_in = 0;
    step(); chk("R7 release+1", wake_out, 1);
    step(); chk("R7 release+2", wake_out, 1);
    step(); chk("R7 release+3", wake_out, 0);
    chk("R8 no event on fall", dbg_event, 0);

    // R9: event wins over a simultaneous acknowledge
    sw_ack = 1;
    ude_in = 1;
    step(); step(); ude_state("R9 event w/ ack", 1, 0, 0);
    step(); ude_state("R9 set wins", 0, 1, 1);
    step(); ude_state("R9 ack after set", 0, 1, 0);
    sw_ack = 0;
    ude_in = 0;
    step(); step(); step();
    chk("R7 wake down", wake_out, 0);

    // R9: external debug mode clears pending; R5 mode alone does not wake
    ude_in = 1;
    step(); step(); step();
    chk("R9 pend set", dbg_pend, 1);
    ude_in = 0;
    step(); step(); step();
    chk("R9 pend sticky", dbg_pend, 1);
    ext_dbg_mode = 1;
    step();
    chk("R9 mode clears", dbg_pend, 0);
    chk("R5 mode alone", wake_out, 0);
    ext_dbg_mode = 0;

    // R2: reset mid-run clears outputs
    wait_en = 1; mode_sel = 3'b010; irq_pending = 1;
    step();
    chk("R1 nap", lp_req, 2);
    rst_n = 0;
    #1;
    chk("R2 async lp_req", lp_req, 0);
    chk("R2 async wake", wake_out, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule